// File: doc/BRIEF.md
# Serial Configuration EEPROM Read Responder

This block stands in for a small serial configuration EEPROM behind a host control register. Software drives the serial pins by writing that register: a clock bit, a data-in bit and an access-request bit. The block treats every write that moves the clock bit from 0 to 1 as one serial clock edge. It collects an 8-bit command, then either an 8-bit byte address followed by a 16-bit word sent back most significant bit first, or eight zero status bits. Each data-out bit stays on `dout_o` until the next edge.

The image holds 64 words of 16 bits. Words 0 to 2 carry a 48-bit station address taken from a parameter. The last word is a checksum chosen so that all 64 words add up to a fixed constant. Every other word is zero. The request bit is granted on the same write that raises it. Unknown commands and word indices past the end of the image set a sticky error flag.

Top module: `eeprom_emu`

## Requirements
- R1: After reset, `dout_o`, `gnt_o` and `err_o` are all 0 and the command, address and bit counters are empty.
- R2: A bit is processed only on a cycle with `wr_en_i` high and `sck_i` high, when the previously written clock bit was 0. Writes that keep the clock bit high or lower it, and cycles without a write, change neither `dout_o` nor the bit position.
- R3: The first 8 processed edges shift `din_i` into the command, MSB first. Command 0x03 is a word read and 0x05 is a status read.
- R4: For a word read, the next 8 edges shift in a byte address, MSB first. The word index is that address shifted right by one, so address bit 0 is ignored.
- R5: For a word read, the next 16 edges set `dout_o` to word bits 15 down to 0, one bit per edge. The value is visible from the cycle after the write and holds until the next edge.
- R6: For a status read, each of the 8 edges after the command sets `dout_o` to 0.
- R7: After the 16th data edge of a word read, or the 8th of a status read, the counters, command and address clear, and the next edge starts a new command.
- R8: When the 8th command bit yields a value other than 0x03 or 0x05, `err_o` is set and stays 1 until reset. The command state clears so that the next edge starts a new command.
- R9: A word index of 64 or more drives `dout_o` to 0 on every data edge and sets `err_o`.
- R10: On every register write, `gnt_o` takes the written `req_i`; between writes it holds.
- R11: The image has words 0, 1 and 2 equal to station address bits [47:32], [31:16] and [15:0], words 3 to 62 equal to 0, and word 63 chosen so that the 16-bit sum of all 64 words is 0xBABA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| sck_i | input | 1 | Written serial clock bit |
| din_i | input | 1 | Written serial data-in bit |
| req_i | input | 1 | Written access request bit |
| dout_o | output | 1 | Serial data-out bit |
| gnt_o | output | 1 | Access grant, follows the last written request |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench reads every word of the image, including the three station address words, and checks the 16-bit sum. This separates a correct checksum word from a wrong word order or a wrong constant. An odd byte address is sent to show that address bit 0 is dropped. Extra writes that hold the clock high or lower it are inserted inside a read: if they counted as edges, the word read back would be shifted. A word read ending on a 1, then a status read, shows the status path forcing zeros. A read started directly after it shows that the counters clear. An unknown command followed by a good read separates the sticky flag from a stuck shifter, and an address in the upper half of the range exercises the out-of-range path.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;
  localparam int unsigned OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_READ = 8'h03;
  localparam logic [OPC_W-1:0] OPC_STAT = 8'h05;
  localparam int unsigned STAT_BITS = 8;
  localparam logic [15:0] CSUM_DEF = 16'hBABA;
endpackage

// File: rtl/eeprom_emu_image.sv
module eeprom_emu_image #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 64,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STA_W  = 48,
  parameter logic [STA_W-1:0]  STATION = '0,
  parameter logic [WORD_W-1:0] CSUM    = '0
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned NAW   = STA_W / WORD_W;
  localparam int unsigned SEL_W = (NAW > 1) ? $clog2(NAW) : 1;

  logic [WORD_W-1:0] sta_w [NAW];
  logic [WORD_W-1:0] sta_sum;
  logic [WORD_W-1:0] csum_w;

  for (genvar g = 0; g < NAW; g++) begin : g_sta
    assign sta_w[g] = STATION[STA_W-1-g*WORD_W -: WORD_W];
  end

  always_comb begin
    sta_sum = '0;
    for (int k = 0; k < NAW; k++) sta_sum = sta_sum + sta_w[k];
  end

  // last word balances the image sum to CSUM
  assign csum_w = CSUM - sta_sum;

  always_comb begin
    word_o = '0;
    if (32'(idx_i) < NAW)             word_o = sta_w[idx_i[SEL_W-1:0]];
    else if (32'(idx_i) == WORDS - 1) word_o = csum_w;
  end
endmodule

// File: rtl/eeprom_emu_shifter.sv
module eeprom_emu_shifter
  import eeprom_emu_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                sck_i,
  input  logic                din_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [ADDR_W-2:0]   idx_o,
  output logic                dout_o,
  output logic                err_o
);
  localparam int unsigned OCNT_W = $clog2(OPC_W + 1);
  localparam int unsigned ACNT_W = $clog2(ADDR_W + 1);
  localparam int unsigned DCNT_W = $clog2(WORD_W);
  localparam logic [OCNT_W-1:0] OP_FULL  = OCNT_W'(OPC_W);
  localparam logic [OCNT_W-1:0] OP_LAST  = OCNT_W'(OPC_W - 1);
  localparam logic [ACNT_W-1:0] AD_FULL  = ACNT_W'(ADDR_W);
  localparam logic [DCNT_W-1:0] RD_LAST  = DCNT_W'(WORD_W - 1);
  localparam logic [DCNT_W-1:0] ST_LAST  = DCNT_W'(STAT_BITS - 1);

  logic              sck_q;
  logic [OPC_W-1:0]  op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OCNT_W-1:0] op_cnt;
  logic [ACNT_W-1:0] ad_cnt;
  logic [DCNT_W-1:0] dt_cnt;

  logic              sck_rise, op_done, is_rd, is_st, out_rng, rd_bit;
  logic [OPC_W-1:0]  op_nx;
  logic [WORD_W-1:0] word_sh;

  assign sck_rise = wr_en_i & sck_i & ~sck_q;
  assign op_done  = (op_cnt == OP_FULL);
  assign is_rd    = (op_q == OPC_READ);
  assign is_st    = (op_q == OPC_STAT);
  assign op_nx    = {op_q[OPC_W-2:0], din_i};
  assign idx_o    = addr_q[ADDR_W-1:1];
  assign out_rng  = 32'(idx_o) >= WORDS;
  assign word_sh  = word_i << dt_cnt;
  assign rd_bit   = word_sh[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      op_cnt <= '0;
      ad_cnt <= '0;
      dt_cnt <= '0;
      dout_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (wr_en_i) sck_q <= sck_i;
      if (sck_rise) begin
        if (!op_done) begin
          if (op_cnt == OP_LAST && op_nx != OPC_READ && op_nx != OPC_STAT) begin
            err_o  <= 1'b1;
            op_q   <= '0;
            op_cnt <= '0;
          end else begin
            op_q   <= op_nx;
            op_cnt <= op_cnt + 1'b1;
          end
        end else if (is_rd && ad_cnt != AD_FULL) begin
          addr_q <= {addr_q[ADDR_W-2:0], din_i};
          ad_cnt <= ad_cnt + 1'b1;
        end else begin
          if (is_rd) begin
            dout_o <= out_rng ? 1'b0 : rd_bit;
            if (out_rng) err_o <= 1'b1;
          end else begin
            dout_o <= 1'b0;
          end
          if ((is_rd && dt_cnt == RD_LAST) || (is_st && dt_cnt == ST_LAST)) begin
            op_q   <= '0;
            addr_q <= '0;
            op_cnt <= '0;
            ad_cnt <= '0;
            dt_cnt <= '0;
          end else begin
            dt_cnt <= dt_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R2
  no_edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_rise |=> ($stable(dout_o) && $stable(dt_cnt) && $stable(op_cnt) && $stable(ad_cnt)));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R3
  op_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_cnt <= OP_FULL);
  // R5
  data_after_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && dt_cnt != '0) |-> (op_done && ad_cnt == AD_FULL));
  // R9
  out_rng_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && op_done && is_rd && ad_cnt == AD_FULL && out_rng) |=> (!dout_o && err_o));
endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu
  import eeprom_emu_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 64,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STA_W  = 48,
  parameter logic [STA_W-1:0]  STATION = 48'h021A_2B3C_4D5F,
  parameter logic [WORD_W-1:0] CSUM    = CSUM_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic sck_i,
  input  logic din_i,
  input  logic req_i,
  output logic dout_o,
  output logic gnt_o,
  output logic err_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;

  eeprom_emu_shifter #(
    .WORD_W(WORD_W), .WORDS(WORDS), .ADDR_W(ADDR_W)
  ) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .sck_i(sck_i),
    .din_i(din_i), .word_i(word), .idx_o(idx), .dout_o(dout_o), .err_o(err_o)
  );

  eeprom_emu_image #(
    .WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W), .STA_W(STA_W),
    .STATION(STATION), .CSUM(CSUM)
  ) u_img (
    .idx_i(idx), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gnt_o <= 1'b0;
    else if (wr_en_i) gnt_o <= req_i;
  end

  // R10
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(gnt_o));
endmodule

// File: tb/eeprom_emu_tb.sv
module eeprom_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA = 48'h021A_2B3C_4D5F;
  localparam logic [15:0] SUM_EXP = 16'hBABA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, sck = 1'b0, din = 1'b0, req = 1'b0;
  logic dout, gnt, err;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_emu #(.STATION(STA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .sck_i(sck), .din_i(din),
    .req_i(req), .dout_o(dout), .gnt_o(gnt), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; sck = 1'b0; din = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic s, input logic d, input logic r);
    @(negedge clk); wr_en = 1'b1; sck = s; din = d; req = r;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic d);
    wr(1'b0, d, 1'b0);
    wr(1'b1, d, 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i]);
  endtask

  task automatic read_word(input logic [7:0] addr, output logic [15:0] w);
    send_byte(8'h03);
    send_byte(addr);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      w = {w[14:0], dout};
    end
  endtask

  task automatic t_reset();
    chk("R1 dout", 32'(dout), 0);
    chk("R1 gnt", 32'(gnt), 0);
    chk("R1 err", 32'(err), 0);
  endtask

  task automatic t_grant();
    wr(1'b0, 1'b0, 1'b1);
    chk("R10 gnt set", 32'(gnt), 1);
    repeat (3) @(negedge clk);
    chk("R10 gnt hold", 32'(gnt), 1);
    wr(1'b0, 1'b0, 1'b0);
    chk("R10 gnt clear", 32'(gnt), 0);
  endtask

  task automatic t_station();
    logic [15:0] w;
    read_word(8'h00, w); chk("R11 word0", 32'(w), 32'(STA[47:32]));
    read_word(8'h02, w); chk("R4 word1", 32'(w), 32'(STA[31:16]));
    read_word(8'h04, w); chk("R5 word2", 32'(w), 32'(STA[15:0]));
    read_word(8'h03, w); chk("R4 odd address", 32'(w), 32'(STA[31:16]));
    chk("R9 no err in range", 32'(err), 0);
  endtask

  task automatic t_image();
    logic [15:0] w, sum;
    int nz;
    sum = '0; nz = 0;
    for (int i = 0; i < 64; i++) begin
      read_word(8'(2*i), w);
      sum = sum + w;
      if (i >= 3 && i < 63 && w != 0) nz++;
    end
    chk("R11 image sum", 32'(sum), 32'(SUM_EXP));
    chk("R11 middle words zero", 32'(nz), 0);
    chk("R3 err after reads", 32'(err), 0);
  endtask

  task automatic t_hold();
    logic [15:0] w;
    logic held;
    int moved;
    moved = 0;
    send_byte(8'h03);
    send_byte(8'h04);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      held = dout;
      wr(1'b1, 1'b1, 1'b0);
      if (dout !== held) moved++;
      wr(1'b0, 1'b1, 1'b0);
      if (dout !== held) moved++;
      repeat (2) @(negedge clk);
      if (dout !== held) moved++;
      w = {w[14:0], dout};
    end
    chk("R2 dout unchanged by non-edges", 32'(moved), 0);
    chk("R2 word intact", 32'(w), 32'(STA[15:0]));
    chk("R5 last bit held", 32'(dout), 32'(STA[0]));
  endtask

  task automatic t_status();
    logic [15:0] w;
    int ones;
    ones = 0;
    send_byte(8'h05);
    chk("R6 dout before status data", 32'(dout), 1);
    for (int i = 0; i < 8; i++) begin
      pulse(1'b1);
      if (dout !== 1'b0) ones++;
    end
    chk("R6 status bits zero", 32'(ones), 0);
    read_word(8'h00, w);
    chk("R7 read after status", 32'(w), 32'(STA[47:32]));
    chk("R6 no err", 32'(err), 0);
  endtask

  task automatic t_bad();
    logic [15:0] w;
    send_byte(8'hA5);
    chk("R8 err on bad opcode", 32'(err), 1);
    read_word(8'h02, w);
    chk("R8 read after bad opcode", 32'(w), 32'(STA[31:16]));
    chk("R8 err sticky", 32'(err), 1);
  endtask

  task automatic t_range();
    logic [15:0] w;
    do_reset();
    chk("R1 err after reset", 32'(err), 0);
    read_word(8'h80, w);
    chk("R9 out of range data", 32'(w), 0);
    chk("R9 out of range err", 32'(err), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_grant();
    t_station();
    t_image();
    t_hold();
    t_status();
    t_bad();
    t_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule